// File: doc/BRIEF.md
# I2C Slave Byte Controller with Windowed Direction Control

This block is a byte-level I2C slave that software runs through three registers. It samples the open-drain SCL and SDA lines through a synchronizer and detects START, repeated START and STOP. It compares the first byte after a START with a fixed 7-bit address. After that it moves data bytes in either direction, each as 8 bits followed by an acknowledge clock.

Between bytes the slave holds SCL low, so software has time to act. Software releases the clock by accessing the data register in the way that suits the current direction: a read when receiving, a write when transmitting. The write also supplies the next byte to send.

The transfer direction comes from a bit in the control register, and the block only accepts a change to it at certain times. A write that lands in the window takes effect at once. The window opens at the rising edge of the acknowledge clock or at a STOP, and closes at the next SCL rise. A write outside the window is parked as pending and takes effect at the next acknowledge-clock rise or STOP. Until then the old direction stays in force, including for an address byte that follows a repeated START.

Top module: `i2c_win_slave`

## Requirements
- R1: After reset the block releases SCL and SDA, the effective direction is receive, nothing is pending, and the status register reads 0x00.
- R2: An address byte whose upper 7 bits equal `SLV_ADDR` gets SDA pulled low on its 9th clock, provided the effective direction is receive. Any other address gets no ACK and no clock stretch, and the slave ignores the bus until the next START.
- R3: Once an addressed slave finishes the 9th clock of a byte, it holds SCL low after that clock falls, until the data register is accessed in the current direction or a START or STOP occurs.
- R4: In receive, data is sampled MSB first on SCL rises. Each byte is acknowledged. A read of register 1 returns the last byte received and releases the stretch.
- R5: In transmit, a write to register 1 during the stretch loads the byte and releases SCL. The byte goes out MSB first, each bit changing while SCL is low, and SDA is released on the 9th clock. A NACK from the master (SDA high at the 9th rise) returns the slave to idle with no stretch.
- R6: A direction write (register 0, bit 0; 1 = transmit) is applied at once if it comes after a 9th-clock rise or a STOP and before the next SCL rise.
- R7: A direction write at any other time sets the pending flag and leaves the effective direction unchanged. The pending value is applied at the next 9th-clock rise or STOP.
- R8: The ACK for an address byte, including one after a repeated START, depends only on the effective direction at that time. A pending receive does not cause an ACK while the effective direction is transmit.
- R9: A data-register read while the effective direction is transmit, or a write while it is receive, does not release the stretch. It sets the mismatch status bit, which clears at the next START.
- R10: The register select is 0 for control, 1 for data and 2 for status. Reads return their value on the cycle after the read strobe. Status bits are: [0] effective direction, [1] pending, [2] SCL stretch active, [3] R/W bit of the last address byte, [4] addressed (data phase), [5] mismatch.
- R11: The slave changes SDA only while SCL is low, except when a START or STOP resets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| reg_sel | input | 2 | Register select (0 control, 1 data, 2 status) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, valid one cycle after reg_rd |

## Verification
The hardest case to reach is a direction write that lands inside a byte, after the window has closed. This case is the only way to see that the effective and pending values differ, and that an address byte after a repeated START is judged by the stale effective value. The bench's master model takes a hook that makes a register write and a status read between two bits of a byte, while the master itself holds SCL low. The hook is used twice: once to defer a switch to transmit across a received data byte, and once to park a switch to receive before an address byte, so the address goes unacknowledged while the following repeated START is acknowledged. A further case parks a write in the middle of a byte and then ends the transfer with a STOP, which checks the STOP path of the deferral.

// File: rtl/i2c_win_pkg.sv
package i2c_win_pkg;
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_DATA = 2'd1;
  localparam logic [1:0] SEL_STAT = 2'd2;

  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_DATA} phase_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_p, sda_p;

  generate
    if (STAGES > 1) begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= {scl_ff[STAGES-2:0], scl_i};
          sda_ff <= {sda_ff[STAGES-2:0], sda_i};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= scl_i;
          sda_ff <= sda_i;
        end
      end
    end
  endgenerate

  assign scl_s = scl_ff[STAGES-1];
  assign sda_s = sda_ff[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_dir_window.sv
module i2c_dir_window (
  input  logic clk,
  input  logic rst,
  input  logic ninth_rise,
  input  logic stop_ev,
  input  logic scl_rise,
  input  logic dir_wr,
  input  logic dir_wdata,
  output logic dir_eff,
  output logic dir_pend,
  output logic win_open
);
  logic pend_val;
  logic apply;

  assign apply = ninth_rise | stop_ev;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_open <= 1'b1;
      dir_eff  <= 1'b0;
      dir_pend <= 1'b0;
      pend_val <= 1'b0;
    end else begin
      if (apply)         win_open <= 1'b1;
      else if (scl_rise) win_open <= 1'b0;

      if (dir_wr && (win_open || apply)) begin
        dir_eff  <= dir_wdata;
        dir_pend <= 1'b0;
      end else if (dir_wr) begin
        dir_pend <= 1'b1;
        pend_val <= dir_wdata;
      end else if (apply && dir_pend) begin
        dir_eff  <= pend_val;
        dir_pend <= 1'b0;
      end
    end
  end

  // R7
  dir_change_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(dir_eff) |-> $past(dir_wr && (win_open || apply)) || $past(apply && dir_pend));

  // R6
  pend_window_chk: assert property (@(posedge clk) disable iff (rst)
    win_open |-> !dir_pend);
endmodule

// File: rtl/i2c_win_slave.sv
module i2c_win_slave
  import i2c_win_pkg::*;
#(
  parameter int              BYTE_W      = 8,
  parameter int              SYNC_STAGES = 2,
  parameter logic [BYTE_W-2:0] SLV_ADDR  = 7'h42
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic [1:0] reg_sel,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic dir_eff, dir_pend, win_open;
  phase_t phase;
  logic [CNT_W-1:0] bitcnt;
  logic [BYTE_W-1:0] rx_sr, tx_sr;
  logic after9, ack_given, rw_bit, mism, tx_byte;
  logic ninth_rise, data_rd, data_wr, good_rd, good_wr;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  assign ninth_rise = scl_rise && (bitcnt == LAST) && (phase != PH_IDLE);

  i2c_dir_window u_dir (
    .clk(clk), .rst(rst), .ninth_rise(ninth_rise), .stop_ev(stop_ev),
    .scl_rise(scl_rise), .dir_wr(reg_wr && reg_sel == SEL_CTRL),
    .dir_wdata(reg_wdata[0]), .dir_eff(dir_eff), .dir_pend(dir_pend),
    .win_open(win_open)
  );

  assign data_rd = reg_rd && (reg_sel == SEL_DATA);
  assign data_wr = reg_wr && (reg_sel == SEL_DATA);
  assign good_rd = data_rd && !dir_eff;
  assign good_wr = data_wr && dir_eff;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE; bitcnt <= '0; after9 <= 1'b0; ack_given <= 1'b0;
      rx_sr <= '0; tx_sr <= '0; rw_bit <= 1'b0; mism <= 1'b0;
      tx_byte <= 1'b0; scl_oe <= 1'b0; sda_oe <= 1'b0;
    end else if (start_ev) begin
      phase <= PH_ADDR; bitcnt <= '0; after9 <= 1'b0; ack_given <= 1'b0;
      mism <= 1'b0; tx_byte <= 1'b0; scl_oe <= 1'b0; sda_oe <= 1'b0;
    end else if (stop_ev) begin
      phase <= PH_IDLE; bitcnt <= '0; after9 <= 1'b0; ack_given <= 1'b0;
      tx_byte <= 1'b0; scl_oe <= 1'b0; sda_oe <= 1'b0;
    end else begin
      if (phase != PH_IDLE) begin
        if (scl_rise) begin
          if (bitcnt == LAST) begin
            bitcnt <= '0;
            after9 <= 1'b1;
            if (phase == PH_ADDR)     phase <= ack_given ? PH_DATA : PH_IDLE;
            else if (tx_byte && sda_s) phase <= PH_IDLE;
          end else begin
            bitcnt <= bitcnt + CNT_W'(1);
            if (!tx_byte) rx_sr <= {rx_sr[BYTE_W-2:0], sda_s};
          end
        end else if (scl_fall) begin
          if (after9) begin
            after9    <= 1'b0;
            sda_oe    <= 1'b0;
            ack_given <= 1'b0;
            if (phase == PH_DATA) scl_oe <= 1'b1;
          end else if (bitcnt == LAST) begin
            if (phase == PH_ADDR) begin
              rw_bit <= rx_sr[0];
              if (rx_sr[BYTE_W-1:1] == SLV_ADDR && !dir_eff) begin
                sda_oe    <= 1'b1;
                ack_given <= 1'b1;
              end
            end else begin
              sda_oe <= !tx_byte;
            end
          end else if (tx_byte && bitcnt != '0) begin
            tx_sr  <= tx_sr << 1;
            sda_oe <= ~tx_sr[BYTE_W-2];
          end
        end
      end
      if (scl_oe) begin
        if (good_rd) begin
          scl_oe  <= 1'b0;
          tx_byte <= 1'b0;
        end else if (good_wr) begin
          scl_oe  <= 1'b0;
          tx_byte <= 1'b1;
          tx_sr   <= reg_wdata;
          sda_oe  <= ~reg_wdata[BYTE_W-1];
        end else if (data_rd || data_wr) begin
          mism <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_sel)
        SEL_CTRL: reg_rdata <= BYTE_W'(dir_eff);
        SEL_DATA: reg_rdata <= rx_sr;
        SEL_STAT: reg_rdata <= BYTE_W'({mism, phase == PH_DATA, rw_bit, scl_oe, dir_pend, dir_eff});
        default:  reg_rdata <= '0;
      endcase
    end
  end

  // R11
  sda_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !$past(scl_s) || $past(start_ev || stop_ev));

  // R3
  stretch_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(scl_oe) |-> $past(good_rd || good_wr || start_ev || stop_ev));

  // R8
  addr_ack_dir_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) && $past(phase == PH_ADDR) |-> !$past(dir_eff));

  // R2
  addr_ack_match_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) && $past(phase == PH_ADDR) |-> $past(rx_sr[BYTE_W-1:1] == SLV_ADDR));
endmodule

// File: tb/i2c_win_slave_test.sv
module i2c_win_slave_test;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_oe, sda_oe;
  logic scl_i, sda_i;
  logic [1:0] reg_sel = 2'd0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;

  int n_chk = 0, n_err = 0, r11_viol = 0;
  logic [7:0] byte_q[$];
  logic [7:0] mon_got;
  string mon_req;
  event mon_ev;
  logic mid_en = 1'b0, mid_val = 1'b0;
  logic [7:0] mid_exp = 8'h00;
  string mid_req = "";

  always #5 clk = ~clk;

  assign scl_i = m_scl & ~scl_oe;
  assign sda_i = m_sda & ~sda_oe;

  i2c_win_slave uut (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_sel(reg_sel),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: compares each produced byte with the queued expectation
  initial forever begin
    @(mon_ev);
    if (byte_q.size() == 0) chk(mon_req, int'(mon_got), -1);
    else chk(mon_req, int'(mon_got), int'(byte_q.pop_front()));
  end

  // R11: SDA driven by the slave never changes while SCL stays high
  logic scl_prev = 1'b1, sda_oe_prev = 1'b0;
  always @(negedge clk) begin
    if (!rst && sda_oe !== sda_oe_prev && scl_prev && scl_i) r11_viol++;
    scl_prev = scl_i;
    sda_oe_prev = sda_oe;
  end

  task automatic cpu_wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic cpu_rd(input logic [1:0] s, output logic [7:0] d);
    @(negedge clk); reg_sel = s; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_x(input logic b, output logic s);
    m_sda = b; idle(Q);
    m_scl = 1'b1; wait (scl_i == 1'b1); idle(Q);
    s = sda_i; m_scl = 1'b0; idle(Q);
  endtask

  task automatic mbyte(input logic [7:0] d, input logic nine,
                       output logic [7:0] got, output logic acked);
    logic s;
    logic [7:0] st;
    got = 8'h00;
    for (int i = 7; i >= 0; i--) begin
      if (mid_en && i == 3) begin
        cpu_wr(2'd0, {7'b0, mid_val});
        cpu_rd(2'd2, st);
        chk(mid_req, int'(st), int'(mid_exp));
        mid_en = 1'b0;
      end
      bit_x(d[i], s);
      got = {got[6:0], s};
    end
    bit_x(nine, s);
    acked = !s;
  endtask

  task automatic m_start;
    m_sda = 1'b1; idle(Q);
    m_scl = 1'b1; wait (scl_i == 1'b1); idle(Q);
    m_sda = 1'b0; idle(Q);
    m_scl = 1'b0; idle(Q);
  endtask

  task automatic m_stop;
    m_sda = 1'b0; idle(Q);
    m_scl = 1'b1; wait (scl_i == 1'b1); idle(Q);
    m_sda = 1'b1; idle(Q);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] g, st;
    logic a, s;
    idle(5); rst = 1'b0; idle(5);
    chk("R1 scl_oe", scl_oe, 0);
    chk("R1 sda_oe", sda_oe, 0);
    cpu_rd(2'd2, st); chk("R1 status", st, 8'h00);

    // wrong address: no ack, no stretch
    m_start; mbyte(8'h42, 1'b1, g, a);
    chk("R2 wrong addr ack", a, 0);
    idle(Q); chk("R2 wrong addr stretch", scl_oe, 0);
    m_stop;

    // receive transfer
    m_start; mbyte(8'h84, 1'b1, g, a);
    chk("R2 match ack", a, 1);
    idle(Q); chk("R3 stretch after addr", scl_oe, 1);
    cpu_rd(2'd2, st); chk("R10 status addressed write", st, 8'h14);
    cpu_rd(2'd1, st); chk("R3 release by read", scl_oe, 0);
    byte_q.push_back(8'h5A);
    mbyte(8'h5A, 1'b1, g, a); chk("R4 data ack", a, 1);
    idle(Q);
    cpu_wr(2'd1, 8'h77); idle(2);
    chk("R9 write in receive keeps stretch", scl_oe, 1);
    cpu_rd(2'd2, st); chk("R9 mismatch flag", st, 8'h34);
    cpu_rd(2'd1, mon_got); mon_req = "R4 received byte"; -> mon_ev;
    idle(1); chk("R4 release after read", scl_oe, 0);
    byte_q.push_back(8'hC3);
    mid_en = 1'b1; mid_val = 1'b1; mid_exp = 8'h32; mid_req = "R7 pending mid byte";
    mbyte(8'hC3, 1'b1, g, a); chk("R7 ack uses old direction", a, 1);
    idle(Q);
    cpu_rd(2'd2, st); chk("R7 applied at 9th rise", st, 8'h35);
    cpu_rd(2'd1, st); idle(1); chk("R9 read in transmit keeps stretch", scl_oe, 1);
    cpu_wr(2'd0, 8'h00);
    cpu_rd(2'd2, st); chk("R6 immediate in window", st, 8'h34);
    cpu_rd(2'd1, mon_got); mon_req = "R4 second byte"; -> mon_ev;
    m_stop;

    // transmit transfer
    m_start; mbyte(8'h85, 1'b1, g, a);
    chk("R2 read addr ack", a, 1);
    idle(Q);
    cpu_rd(2'd2, st); chk("R10 status rw bit", st, 8'h1C);
    cpu_wr(2'd0, 8'h01);
    cpu_rd(2'd2, st); chk("R6 switch to transmit", st, 8'h1D);
    byte_q.push_back(8'hA5); cpu_wr(2'd1, 8'hA5);
    mbyte(8'hFF, 1'b0, mon_got, a); mon_req = "R5 transmitted byte"; -> mon_ev;
    idle(Q); chk("R3 stretch after tx byte", scl_oe, 1);
    byte_q.push_back(8'h3C); cpu_wr(2'd1, 8'h3C);
    mbyte(8'hFF, 1'b1, mon_got, a); mon_req = "R5 second tx byte"; -> mon_ev;
    idle(Q); chk("R5 nack no stretch", scl_oe, 0);
    cpu_rd(2'd2, st); chk("R5 idle after nack", st, 8'h09);
    m_stop;

    // effective transmit with pending receive: address not acknowledged
    m_start;
    mid_en = 1'b1; mid_val = 1'b0; mid_exp = 8'h0B; mid_req = "R7 pending in address";
    mbyte(8'h84, 1'b1, g, a);
    chk("R8 no ack while transmit", a, 0);
    cpu_rd(2'd2, st); chk("R7 pending applied", st, 8'h00);
    m_start; mbyte(8'h84, 1'b1, g, a);
    chk("R8 ack after repeated start", a, 1);
    idle(Q); chk("R3 stretch after repeated start", scl_oe, 1);
    cpu_rd(2'd1, st);
    m_stop;

    // pending applied by STOP
    m_start;
    for (int k = 0; k < 3; k++) bit_x(1'b1, s);
    cpu_wr(2'd0, 8'h01);
    cpu_rd(2'd2, st); chk("R7 pending before stop", st, 8'h02);
    m_stop; idle(Q);
    cpu_rd(2'd2, st); chk("R7 applied at stop", st, 8'h01);

    chk("R11 sda stable while scl high", r11_viol, 0);
    idle(5);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule